// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of an out-of-order execution engine with a handful of functional units: an integer/load unit, an adder, a multiplier and a divider. A front end presents one decoded instruction at a time: an operation code, a destination register, two source registers and the number of the unit that should run it. The controller accepts it only when that unit is idle and no earlier instruction still owns the destination. It then decides when each unit may fetch its operands from the register file, and when a unit that reports completion may write its result back.

Two tables hold the state. One row per functional unit records the operation, the destination, both source registers, the units that will produce each source, and a flag per source that marks it as ready and not yet fetched. One entry per architectural register names the unit that will write it next, or zero if none will. Read-after-write hazards are resolved by waiting for the producing unit's write-back. Write-after-write hazards stall issue. Write-after-read hazards hold a write-back until every unit that still needs the old value has fetched it. There is no forwarding path, and the datapaths and register file sit outside the block.

Top module: `scb_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every unit and every register entry is free. No read or write grant is raised, and `iss_ready` is high for any in-range unit code.
- R2: Unit codes run from 1 to NUM_FU, and code k selects grant bit k-1. An instruction is accepted on a clock edge where `iss_valid` and `iss_ready` are both high. `iss_ready` is high exactly when the code is in range, the selected unit is idle and no unit owns the destination. Codes 0 and above NUM_FU are never accepted.
- R3: While any unit owns the destination register, `iss_ready` stays low. It rises in the cycle after that owner's write grant.
- R4: While the selected unit is busy, `iss_ready` stays low. It rises in the cycle after that unit's write grant.
- R5: An issued instruction whose sources have no pending producer becomes eligible for a read grant in the cycle after its issue edge. At most one read grant is raised per cycle, and it goes to the lowest-numbered eligible unit.
- R6: A source with a pending producer holds its consumer's read grant until the cycle after the producer's write grant.
- R7: An `exec_done` bit has no effect unless its unit is executing, which means its read grant has already been given. An instruction whose done pulse arrives in cycle t gets its write grant from cycle t+1 at the earliest.
- R8: A unit whose done pulse was accepted in cycle t is granted the write in cycle t+1 when no hazard blocks it. At most one write grant is raised per cycle, and it goes to the lowest-numbered eligible unit. A write grant never coincides with a read grant on the same unit.
- R9: A completed unit is not granted its write while another unit still waits to read a source equal to its destination with that source marked ready. The write follows in the cycle after that reader's read grant.
- R10: An instruction issued in the same cycle that its source's producer receives the write grant treats that source as ready. It becomes eligible for its read grant in the next cycle.
- R11: Each issued instruction receives exactly one read grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Decoded instruction is presented |
| iss_ready | output | 1 | Instruction can be accepted this cycle |
| iss_op | input | OP_W | Operation code stored with the unit |
| iss_dst | input | REG_W | Destination register |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| iss_unit | input | TAG_W | Target functional unit, 1..NUM_FU |
| exec_done | input | NUM_FU | Per-unit execution-complete pulse |
| rd_grant | output | NUM_FU | Per-unit permission to fetch operands this cycle |
| wr_grant | output | NUM_FU | Per-unit permission to write the result this cycle |

## Verification
All state is registered, and both grant vectors and `iss_ready` are decoded from it in the same cycle. An issue or a done pulse presented in cycle t therefore shows its effect in cycle t+1. A write grant in cycle t releases the unit and its destination from cycle t+1, and wakes waiting readers in that same cycle. The bench writes down each expected grant with its exact cycle, unit and kind before it applies the stimulus. At each falling edge a monitor compares every observed grant with the head of that list and reports any grant that is missing, early or extra. Hazard sequences are laid out so that a wrong stage transition shifts a grant by at least one cycle.

// File: rtl/scb_pkg.sv
package scb_pkg;
    parameter int unsigned NUM_FU  = 4;
    parameter int unsigned NUM_REG = 16;
    parameter int unsigned OP_W    = 4;

    localparam int unsigned TAG_W = $clog2(NUM_FU + 1);
    localparam int unsigned REG_W = $clog2(NUM_REG);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [REG_W-1:0]  reg_idx_t;
    typedef logic [OP_W-1:0]   op_t;
    typedef logic [NUM_FU-1:0] fu_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } stage_e;

    typedef struct packed {
        logic     busy;
        stage_e   stage;
        op_t      op;
        reg_idx_t fi;
        reg_idx_t fj;
        reg_idx_t fk;
        tag_t     qj;
        tag_t     qk;
        logic     rj;
        logic     rk;
    } fu_entry_t;

    typedef struct packed {
        op_t      op;
        reg_idx_t dst;
        reg_idx_t src_a;
        reg_idx_t src_b;
        tag_t     qa;
        tag_t     qb;
    } issue_t;

    function automatic fu_vec_t lowest_one(input fu_vec_t v);
        return v & (~v + fu_vec_t'(1));
    endfunction

    function automatic tag_t onehot_to_tag(input fu_vec_t v);
        tag_t t;
        t = '0;
        for (int i = 0; i < int'(NUM_FU); i++) begin
            if (v[i]) t = tag_t'(i + 1);
        end
        return t;
    endfunction
endpackage

// File: rtl/scb_result_table.sv
module scb_result_table
    import scb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_idx_t look_a,
    input  reg_idx_t look_b,
    input  reg_idx_t look_dst,
    output tag_t     own_a,
    output tag_t     own_b,
    output tag_t     own_dst,
    input  logic     set_en,
    input  reg_idx_t set_reg,
    input  tag_t     set_tag,
    input  logic     clr_en,
    input  reg_idx_t clr_reg
);
    tag_t owner_q [NUM_REG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < int'(NUM_REG); r++) owner_q[r] <= '0;
        end else begin
            // issue never targets an owned register, so the two never collide
            if (clr_en) owner_q[clr_reg] <= '0;
            if (set_en) owner_q[set_reg] <= set_tag;
        end
    end

    assign own_a   = owner_q[look_a];
    assign own_b   = owner_q[look_b];
    assign own_dst = owner_q[look_dst];
endmodule

// File: rtl/scb_fu_table.sv
module scb_fu_table
    import scb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   iss_en,
    input  fu_vec_t                iss_sel,
    input  issue_t                 iss_data,
    input  fu_vec_t                rd_grant,
    input  fu_vec_t                wr_grant,
    input  fu_vec_t                done,
    input  logic                   wake_en,
    input  tag_t                   wake_tag,
    output fu_entry_t [NUM_FU-1:0] entries
);
    for (genvar g = 0; g < int'(NUM_FU); g++) begin : g_unit
        fu_entry_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (wr_grant[g]) begin
                ent_q.busy  <= 1'b0;
                ent_q.stage <= ST_IDLE;
                ent_q.rj    <= 1'b0;
                ent_q.rk    <= 1'b0;
                ent_q.qj    <= '0;
                ent_q.qk    <= '0;
            end else if (iss_en && iss_sel[g]) begin
                ent_q <= '{busy:  1'b1,
                           stage: ST_READ,
                           op:    iss_data.op,
                           fi:    iss_data.dst,
                           fj:    iss_data.src_a,
                           fk:    iss_data.src_b,
                           qj:    iss_data.qa,
                           qk:    iss_data.qb,
                           rj:    (iss_data.qa == '0),
                           rk:    (iss_data.qb == '0)};
            end else begin
                if (rd_grant[g]) begin
                    ent_q.rj    <= 1'b0;
                    ent_q.rk    <= 1'b0;
                    ent_q.stage <= ST_EXEC;
                end else if (ent_q.stage == ST_EXEC && done[g]) begin
                    ent_q.stage <= ST_DONE;
                end
                if (wake_en && ent_q.busy && ent_q.qj != '0 && ent_q.qj == wake_tag) begin
                    ent_q.qj <= '0;
                    ent_q.rj <= 1'b1;
                end
                if (wake_en && ent_q.busy && ent_q.qk != '0 && ent_q.qk == wake_tag) begin
                    ent_q.qk <= '0;
                    ent_q.rk <= 1'b1;
                end
            end
        end

        assign entries[g] = ent_q;
    end
endmodule

// File: rtl/scb_hazard.sv
module scb_hazard
    import scb_pkg::*;
(
    input  fu_entry_t [NUM_FU-1:0] entries,
    output fu_vec_t                rd_grant,
    output fu_vec_t                wr_grant
);
    fu_vec_t rd_elig;
    fu_vec_t wr_elig;
    fu_vec_t war_block;

    always_comb begin
        for (int u = 0; u < int'(NUM_FU); u++) begin
            rd_elig[u] = entries[u].busy && entries[u].stage == ST_READ
                         && entries[u].rj && entries[u].rk;
            war_block[u] = 1'b0;
            for (int f = 0; f < int'(NUM_FU); f++) begin
                if (f != u && entries[f].busy) begin
                    if (entries[f].rj && entries[f].fj == entries[u].fi) war_block[u] = 1'b1;
                    if (entries[f].rk && entries[f].fk == entries[u].fi) war_block[u] = 1'b1;
                end
            end
            wr_elig[u] = entries[u].busy && entries[u].stage == ST_DONE && !war_block[u];
        end
    end

    assign rd_grant = lowest_one(rd_elig);
    assign wr_grant = lowest_one(wr_elig);
endmodule

// File: rtl/scb_ctrl.sv
module scb_ctrl
    import scb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [REG_W-1:0]  iss_src_a,
    input  logic [REG_W-1:0]  iss_src_b,
    input  logic [TAG_W-1:0]  iss_unit,
    input  logic [NUM_FU-1:0] exec_done,
    output logic [NUM_FU-1:0] rd_grant,
    output logic [NUM_FU-1:0] wr_grant
);
    fu_entry_t [NUM_FU-1:0] entries;
    fu_vec_t  busy_vec;
    fu_vec_t  unit_sel;
    fu_vec_t  rd_g;
    fu_vec_t  wr_g;
    tag_t     own_a, own_b, own_dst;
    tag_t     wr_tag;
    reg_idx_t wr_dst;
    logic     wr_any;
    logic     unit_ok;
    logic     iss_fire;
    issue_t   iss_data;

    always_comb begin
        wr_dst = '0;
        for (int u = 0; u < int'(NUM_FU); u++) begin
            busy_vec[u] = entries[u].busy;
            unit_sel[u] = (iss_unit == tag_t'(u + 1));
            if (wr_g[u]) wr_dst = entries[u].fi;
        end
    end

    assign wr_any  = |wr_g;
    assign wr_tag  = onehot_to_tag(wr_g);
    assign unit_ok = (iss_unit != '0) && (iss_unit <= tag_t'(NUM_FU));

    assign iss_ready = unit_ok && ((unit_sel & ~busy_vec) != '0) && (own_dst == '0);
    assign iss_fire  = iss_valid && iss_ready;

    // a producer writing back this cycle counts as already available
    always_comb begin
        iss_data.op    = iss_op;
        iss_data.dst   = iss_dst;
        iss_data.src_a = iss_src_a;
        iss_data.src_b = iss_src_b;
        iss_data.qa    = (wr_any && own_a == wr_tag) ? '0 : own_a;
        iss_data.qb    = (wr_any && own_b == wr_tag) ? '0 : own_b;
    end

    scb_result_table u_result (
        .clk      (clk),
        .rst      (rst),
        .look_a   (iss_src_a),
        .look_b   (iss_src_b),
        .look_dst (iss_dst),
        .own_a    (own_a),
        .own_b    (own_b),
        .own_dst  (own_dst),
        .set_en   (iss_fire),
        .set_reg  (iss_dst),
        .set_tag  (iss_unit),
        .clr_en   (wr_any),
        .clr_reg  (wr_dst)
    );

    scb_fu_table u_units (
        .clk      (clk),
        .rst      (rst),
        .iss_en   (iss_fire),
        .iss_sel  (unit_sel),
        .iss_data (iss_data),
        .rd_grant (rd_g),
        .wr_grant (wr_g),
        .done     (exec_done),
        .wake_en  (wr_any),
        .wake_tag (wr_tag),
        .entries  (entries)
    );

    scb_hazard u_hazard (
        .entries  (entries),
        .rd_grant (rd_g),
        .wr_grant (wr_g)
    );

    assign rd_grant = rd_g;
    assign wr_grant = wr_g;
endmodule

// File: rtl/scb_ctrl_chk.sv
module scb_ctrl_chk
    import scb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              iss_ready,
    input logic [TAG_W-1:0]  iss_unit,
    input logic [NUM_FU-1:0] rd_grant,
    input logic [NUM_FU-1:0] wr_grant
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_grant == '0 && wr_grant == '0));

    p_bad_unit_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_unit == '0 || iss_unit > TAG_W'(NUM_FU)) |-> !iss_ready);

    p_rd_single_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_grant));

    p_wr_single_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_grant));

    p_no_rd_wr_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_grant & wr_grant) == '0);

    p_rd_once_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_grant != '0) |=> (rd_grant != $past(rd_grant)));

    p_wr_releases_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_grant != '0) |=> (wr_grant != $past(wr_grant)));
endmodule

bind scb_ctrl scb_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_ready (iss_ready),
    .iss_unit  (iss_unit),
    .rd_grant  (rd_grant),
    .wr_grant  (wr_grant)
);

// File: tb/scb_ctrl_bench.sv
module scb_ctrl_bench;
    import scb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int K_RD = 0;
    localparam int K_WR = 1;

    logic              clk = 1'b0;
    logic              rst;
    logic              iss_valid;
    logic              iss_ready;
    logic [OP_W-1:0]   iss_op;
    logic [REG_W-1:0]  iss_dst, iss_src_a, iss_src_b;
    logic [TAG_W-1:0]  iss_unit;
    logic [NUM_FU-1:0] exec_done;
    logic [NUM_FU-1:0] rd_grant, wr_grant;

    typedef struct {
        int    cyc;
        int    kind;
        int    unit;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    scb_ctrl u_scb_ctrl (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss_valid),
        .iss_ready (iss_ready),
        .iss_op    (iss_op),
        .iss_dst   (iss_dst),
        .iss_src_a (iss_src_a),
        .iss_src_b (iss_src_b),
        .iss_unit  (iss_unit),
        .exec_done (exec_done),
        .rd_grant  (rd_grant),
        .wr_grant  (wr_grant)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input int act, input int expv, input string req, input string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_ev(input int c, input int k, input int u, input string req);
        exp_q.push_back('{c, k, u, req});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic present(input int unit, input int dst, input int sa, input int sb);
        iss_valid = 1'b1;
        iss_unit  = TAG_W'(unit);
        iss_dst   = REG_W'(dst);
        iss_src_a = REG_W'(sa);
        iss_src_b = REG_W'(sb);
        iss_op    = OP_W'(unit + dst);
    endtask

    task automatic idle();
        iss_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: compare every observed grant against the head of the queue
    task automatic observe(input int k, input int u);
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL extra grant kind %0d unit %0d cycle %0d actual present expected none", k, u, cyc);
        end else if (exp_q[0].cyc == cyc && exp_q[0].kind == k && exp_q[0].unit == u) begin
            void'(exp_q.pop_front());
        end else begin
            errors++;
            $display("FAIL %s grant actual kind %0d unit %0d cycle %0d expected kind %0d unit %0d cycle %0d",
                     exp_q[0].req, k, u, cyc, exp_q[0].kind, exp_q[0].unit, exp_q[0].cyc);
            if (exp_q[0].cyc <= cyc) void'(exp_q.pop_front());
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            for (int u = 0; u < int'(NUM_FU); u++) if (rd_grant[u]) observe(K_RD, u);
            for (int u = 0; u < int'(NUM_FU); u++) if (wr_grant[u]) observe(K_WR, u);
            while (exp_q.size() != 0 && exp_q[0].cyc <= cyc) begin
                checks++;
                errors++;
                $display("FAIL %s missing grant actual none expected kind %0d unit %0d cycle %0d",
                         exp_q[0].req, exp_q[0].kind, exp_q[0].unit, exp_q[0].cyc);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        int b;
        rst = 1'b1;
        exec_done = '0;
        idle();
        iss_unit = 1; iss_dst = 1; iss_src_a = 0; iss_src_b = 0; iss_op = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1: idle after reset
        chk(int'(rd_grant), 0, "R1", "rd_grant");
        chk(int'(wr_grant), 0, "R1", "wr_grant");
        chk(int'(iss_ready), 1, "R1", "ready");

        // R2: unit codes outside 1..NUM_FU are never accepted
        present(0, 1, 2, 3); #1;
        chk(int'(iss_ready), 0, "R2", "ready unit 0");
        present(NUM_FU + 1, 1, 2, 3); #1;
        chk(int'(iss_ready), 0, "R2", "ready unit out of range");
        step(); idle(); step(); step();

        // S1: plain issue, read, done, write (R2 R5 R8)
        b = cyc;
        expect_ev(b + 1, K_RD, 0, "R5");
        expect_ev(b + 3, K_WR, 0, "R8");
        present(1, 1, 2, 3); #1;
        chk(int'(iss_ready), 1, "R2", "ready free unit");
        step(); idle();
        step(); exec_done = 4'b0001;
        step(); exec_done = '0;
        step(); step(); step();

        // S2: done pulses outside execution are ignored (R7)
        b = cyc;
        expect_ev(b + 2, K_RD, 1, "R5");
        expect_ev(b + 6, K_WR, 1, "R7");
        exec_done = 4'b0010;
        step(); present(2, 4, 5, 6);
        step(); idle();
        step(); exec_done = '0;
        step();
        step(); exec_done = 4'b0010;
        step(); exec_done = '0;
        step(); step(); step();

        // S3: destination owned stalls issue until owner writes (R3)
        b = cyc;
        expect_ev(b + 1, K_RD, 2, "R5");
        expect_ev(b + 3, K_WR, 2, "R8");
        expect_ev(b + 5, K_RD, 1, "R3");
        expect_ev(b + 7, K_WR, 1, "R8");
        present(3, 8, 1, 2);
        step(); present(2, 8, 1, 2); #1;
        chk(int'(iss_ready), 0, "R3", "ready owned dst");
        step(); exec_done = 4'b0100; #1;
        chk(int'(iss_ready), 0, "R3", "ready owned dst");
        step(); exec_done = '0; #1;
        chk(int'(iss_ready), 0, "R3", "ready during owner write");
        step(); #1;
        chk(int'(iss_ready), 1, "R3", "ready after owner write");
        step(); idle();
        step(); exec_done = 4'b0010;
        step(); exec_done = '0;
        step(); step(); step();

        // S4: RAW wait, WAR hold, busy unit, write priority (R4 R6 R8 R9)
        b = cyc;
        expect_ev(b + 1,  K_RD, 2, "R5");
        expect_ev(b + 3,  K_RD, 1, "R5");
        expect_ev(b + 6,  K_WR, 2, "R8");
        expect_ev(b + 7,  K_RD, 3, "R6");
        expect_ev(b + 8,  K_WR, 1, "R9");
        expect_ev(b + 10, K_RD, 1, "R4");
        expect_ev(b + 12, K_WR, 1, "R8");
        expect_ev(b + 13, K_WR, 3, "R8");
        present(3, 0, 2, 4);
        step(); present(4, 10, 0, 6);
        step(); present(2, 6, 8, 2);
        step(); idle();
        step(); present(2, 13, 1, 1); exec_done = 4'b0010; #1;
        chk(int'(iss_ready), 0, "R4", "ready busy unit");
        step(); exec_done = 4'b0100;
        step(); exec_done = '0;
        step();
        step(); #1;
        chk(int'(iss_ready), 0, "R4", "ready during unit write");
        step(); #1;
        chk(int'(iss_ready), 1, "R4", "ready after unit write");
        step(); idle();
        step(); exec_done = 4'b1010;
        step(); exec_done = '0;
        step(); step(); step(); step();

        // S5: read priority, wakeup and same-cycle write bypass (R5 R6 R10 R11)
        b = cyc;
        expect_ev(b + 1,  K_RD, 0, "R5");
        expect_ev(b + 4,  K_WR, 0, "R8");
        expect_ev(b + 5,  K_RD, 1, "R6");
        expect_ev(b + 6,  K_RD, 2, "R5");
        expect_ev(b + 7,  K_RD, 3, "R10");
        expect_ev(b + 9,  K_WR, 1, "R8");
        expect_ev(b + 10, K_WR, 2, "R8");
        expect_ev(b + 11, K_WR, 3, "R11");
        present(1, 3, 4, 4);
        step(); present(2, 5, 3, 3);
        step(); present(3, 7, 3, 0);
        step(); idle(); exec_done = 4'b0001;
        step(); exec_done = '0; present(4, 9, 3, 3); #1;
        chk(int'(iss_ready), 1, "R10", "ready during producer write");
        step(); idle();
        step(); step();
        step(); exec_done = 4'b1110;
        step(); exec_done = '0;
        step(); step(); step(); step(); step();

        // every expected grant has been seen (R11)
        chk(exp_q.size(), 0, "R11", "pending expectations");
        chk(int'(iss_ready), 1, "R1", "ready when drained");
        finish_run();
    end
endmodule